// File: doc/BRIEF.md
# Addressed SPI command frame decoder

This block is the serial control port of a configurable device that shares its SPI bus with other devices. A host sends 16-bit frames, most significant bit first, with SCLK idle low and data sampled on its rising edge while CS_N is low. The top four bits select a device. The lower twelve bits carry one of ten fixed command codes together with any operand. The block accepts a frame addressed to its own programmed chip address, and it also accepts the two shared addresses 0x0 and 0xF. It then updates a driver-enable flag, a configuration-state flag, a 5-bit register pointer, a small bank of 16-bit registers or its own chip address.

Registers are written one byte at a time, through the pointer, and only while the device is in configuration state. A read command stages a register value, which is shifted out on SDO during the next frame. SDO is a separate data bit plus an output-enable. The enable is raised only by a frame carrying the device's own address. It drops on a broadcast frame or on a frame for another device, so that the shared line is free for others. SCLK, CS_N and SDI are oversampled by the block's system clock.

Top module: `spi_addr_cmd_decoder`

## Requirements
- R1: A frame is acted on only when CS_N rises after exactly 16 rising SCLK edges since it fell. A frame with 15 or 17 edges changes no output and no stored state.
- R2: A complete frame is accepted when bits 15:12 equal the programmed chip address, 0x0 or 0xF. A frame with any other address changes no flag, pointer, register or chip address.
- R3: After reset sdo_oe is 0. A complete frame with the own address (other than 0xF) sets sdo_oe to 1. A frame with address 0xF, or with an address that is neither the own address nor 0x0, clears it. A 0x0 frame when the own address is non-zero leaves it unchanged.
- R4: An accepted body 0x009 sets drv_en to 1 and an accepted body 0x00A clears it. drv_en is 0 after reset.
- R5: An accepted body 0x222 sets cfg_mode to 1. An accepted body 0x009 clears it.
- R6: An accepted frame with bits 11:5 = 1100000 loads the pointer from bits 4:0. Bits 11:8 = 1010 writes frame bits 7:0 into bits 15:8 of the pointed register, and bits 11:8 = 1011 writes them into bits 7:0. Byte writes take effect only while cfg_mode is 1, and a pointer at or beyond REG_COUNT writes nothing.
- R7: An accepted frame with bits 11:5 = 0001000 stages register bits 4:0 (0 if the index is at or beyond REG_COUNT). Any other accepted frame stages 0. The staged word is sent MSB first on sdo during the next frame: its first bit is present from CS_N falling, and each following bit appears after a falling SCLK edge.
- R8: An accepted body 0x708 returns every register to its default, DEF_BASE plus its index. The chip address, pointer and flags are kept.
- R9: A complete frame with bits 15:4 = 0xFDA sets the chip address to bits 3:0. The chip address is 0x0 after reset.
- R10: The body 0x542 and any body matching no command leave flags, pointer, registers and chip address unchanged.
- R11: Synchronous reset clears drv_en, cfg_mode, sdo_oe, the pointer, the chip address and the staged word, and loads every register with its default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock, idle low |
| cs_n | input | 1 | Frame select, active low |
| sdi | input | 1 | Serial data in, MSB first |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Drive enable for the shared SDO line |
| drv_en | output | 1 | Driver output enable flag |
| cfg_mode | output | 1 | Configuration state flag |

## Verification
The bench sends frames of 15 and 17 clocks. A decoder that counted loosely would then raise drv_en on a truncated enable. It changes the chip address and addresses frames to a foreign device. A design with a loose address match would obey them, and one that mishandled the enable would leave sdo_oe high after a broadcast or drop it on a 0x0 frame. It tries byte writes outside configuration state, reads a register past the end of the bank, and checks that a soft reset restores defaults but keeps the chip address. A design that failed here would corrupt registers, return stale data or lose its address. Every read is compared bit by bit on sdo in the following frame, so a shift off by one position shows up as a wrong word.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    localparam int FRAME_W = 16;
    localparam int CA_W    = 4;
    localparam int BODY_W  = FRAME_W - CA_W;
    localparam int PTR_W   = 5;
    localparam int DATA_W  = 16;

    localparam logic [CA_W-1:0]   CA_SHARED = 4'h0;
    localparam logic [CA_W-1:0]   CA_BCAST  = 4'hF;

    localparam logic [BODY_W-1:0] BODY_DRV_ON  = 12'h009;
    localparam logic [BODY_W-1:0] BODY_DRV_OFF = 12'h00A;
    localparam logic [BODY_W-1:0] BODY_CFG     = 12'h222;
    localparam logic [BODY_W-1:0] BODY_NOP     = 12'h542;
    localparam logic [BODY_W-1:0] BODY_SOFTRST = 12'h708;
    localparam logic [6:0]        PFX_READ     = 7'b0001000;
    localparam logic [6:0]        PFX_PTR      = 7'b1100000;
    localparam logic [3:0]        PFX_WR_HI    = 4'hA;
    localparam logic [3:0]        PFX_WR_LO    = 4'hB;
    localparam logic [11:0]       PFX_SET_CA   = 12'hFDA;

    typedef enum logic [3:0] {
        CMD_NONE,
        CMD_DRV_ON,
        CMD_DRV_OFF,
        CMD_CFG,
        CMD_NOP,
        CMD_SOFT_RST,
        CMD_RD,
        CMD_PTR,
        CMD_WR_HI,
        CMD_WR_LO,
        CMD_SET_CA
    } cmd_e;

    typedef struct packed {
        logic [CA_W-1:0]   ca;
        logic [BODY_W-1:0] body;
    } frame_t;

    function automatic cmd_e decode_cmd(frame_t f);
        cmd_e c;
        c = CMD_NONE;
        if ({f.ca, f.body[11:4]} == PFX_SET_CA)      c = CMD_SET_CA;
        else if (f.body == BODY_DRV_ON)              c = CMD_DRV_ON;
        else if (f.body == BODY_DRV_OFF)             c = CMD_DRV_OFF;
        else if (f.body == BODY_CFG)                 c = CMD_CFG;
        else if (f.body == BODY_NOP)                 c = CMD_NOP;
        else if (f.body == BODY_SOFTRST)             c = CMD_SOFT_RST;
        else if (f.body[11:5] == PFX_READ)           c = CMD_RD;
        else if (f.body[11:5] == PFX_PTR)            c = CMD_PTR;
        else if (f.body[11:8] == PFX_WR_HI)          c = CMD_WR_HI;
        else if (f.body[11:8] == PFX_WR_LO)          c = CMD_WR_LO;
        return c;
    endfunction

endpackage

// File: rtl/spi_frame_rx.sv
module spi_frame_rx import spi_cmd_pkg::*; #(
    parameter int WIDTH = FRAME_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sclk,
    input  logic             cs_n,
    input  logic             sdi,
    output logic             frame_ok,
    output logic [WIDTH-1:0] frame_data,
    output logic             sel_start,
    output logic             bit_shift
);
    localparam int CNT_W = $clog2(WIDTH + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WIDTH);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WIDTH + 1);

    logic [2:0]       sclk_sr, cs_sr;
    logic [1:0]       sdi_sr;
    logic [CNT_W-1:0] cnt;
    logic [WIDTH-1:0] shreg;
    logic             active, sclk_rise, sclk_fall, cs_rise, cs_fall;

    assign active    = ~cs_sr[1];
    assign sclk_rise = sclk_sr[1] & ~sclk_sr[2];
    assign sclk_fall = ~sclk_sr[1] & sclk_sr[2];
    assign cs_rise   = cs_sr[1] & ~cs_sr[2];
    assign cs_fall   = ~cs_sr[1] & cs_sr[2];

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_sr  <= '0;
            cs_sr    <= '1;
            sdi_sr   <= '0;
            cnt      <= '0;
            shreg    <= '0;
            frame_ok <= 1'b0;
        end else begin
            sclk_sr  <= {sclk_sr[1:0], sclk};
            cs_sr    <= {cs_sr[1:0], cs_n};
            sdi_sr   <= {sdi_sr[0], sdi};
            frame_ok <= cs_rise && (cnt == CNT_FULL);
            if (cs_fall) begin
                cnt   <= '0;
                shreg <= '0;
            end else if (active && sclk_rise) begin
                shreg <= {shreg[WIDTH-2:0], sdi_sr[1]};
                if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
            end
        end
    end

    assign frame_data = shreg;
    assign sel_start  = cs_fall;
    assign bit_shift  = active & sclk_fall;

    AST_OK_PULSE: assert property (@(posedge clk) disable iff (rst) frame_ok |=> !frame_ok); // R1
    AST_OK_AFTER_SEL: assert property (@(posedge clk) disable iff (rst) frame_ok |-> cs_sr[2]); // R1
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank import spi_cmd_pkg::*; #(
    parameter int                REG_COUNT = 8,
    parameter logic [DATA_W-1:0] DEF_BASE  = 16'hA500
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [PTR_W-1:0]  wr_ptr,
    input  logic [7:0]        wr_byte,
    input  logic [PTR_W-1:0]  rd_ptr,
    output logic [DATA_W-1:0] rd_data
);
    logic [REG_COUNT-1:0][DATA_W-1:0] regs;

    for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
        localparam logic [DATA_W-1:0] DEF_VAL = DEF_BASE + DATA_W'(g);
        logic sel;
        assign sel = (wr_ptr == PTR_W'(g));
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                regs[g] <= DEF_VAL;
            end else begin
                if (wr_hi && sel) regs[g][15:8] <= wr_byte;
                if (wr_lo && sel) regs[g][7:0]  <= wr_byte;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < REG_COUNT; i++) begin
            if (rd_ptr == PTR_W'(i)) rd_data = regs[i];
        end
    end

    AST_REGS_HOLD: assert property (@(posedge clk) disable iff (rst) !(wr_hi || wr_lo || clear) |=> $stable(regs)); // R6
endmodule

// File: rtl/spi_out_shift.sv
module spi_out_shift import spi_cmd_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              shift,
    output logic              sdo
);
    logic [DATA_W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst)        sh <= '0;
        else if (load)  sh <= load_val;
        else if (shift) sh <= {sh[DATA_W-2:0], 1'b0};
    end

    assign sdo = sh[DATA_W-1];

    AST_SDO_HOLD: assert property (@(posedge clk) disable iff (rst) !(load || shift) |=> $stable(sdo)); // R7
endmodule

// File: rtl/spi_addr_cmd_decoder.sv
module spi_addr_cmd_decoder import spi_cmd_pkg::*; #(
    parameter int                REG_COUNT = 8,
    parameter logic [DATA_W-1:0] DEF_BASE  = 16'hA500
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    input  logic cs_n,
    input  logic sdi,
    output logic sdo,
    output logic sdo_oe,
    output logic drv_en,
    output logic cfg_mode
);
    logic              frame_ok, sel_start, bit_shift;
    logic [FRAME_W-1:0] frame_raw;
    frame_t            frm;
    cmd_e              cmd;
    logic              hit, wr_hi, wr_lo, clear;
    logic [CA_W-1:0]   own_q;
    logic [PTR_W-1:0]  ptr_q;
    logic [DATA_W-1:0] rd_data, resp_q;
    logic              drv_q, cfg_q, oe_q;

    spi_frame_rx #(.WIDTH(FRAME_W)) u_rx (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
        .frame_ok(frame_ok), .frame_data(frame_raw),
        .sel_start(sel_start), .bit_shift(bit_shift)
    );

    assign frm = frame_t'(frame_raw);
    assign cmd = decode_cmd(frm);
    assign hit = frame_ok && (frm.ca == own_q || frm.ca == CA_SHARED || frm.ca == CA_BCAST);

    assign wr_hi = hit && cfg_q && (cmd == CMD_WR_HI);
    assign wr_lo = hit && cfg_q && (cmd == CMD_WR_LO);
    assign clear = hit && (cmd == CMD_SOFT_RST);

    spi_reg_bank #(.REG_COUNT(REG_COUNT), .DEF_BASE(DEF_BASE)) u_bank (
        .clk(clk), .rst(rst), .clear(clear),
        .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_ptr(ptr_q), .wr_byte(frm.body[7:0]),
        .rd_ptr(frm.body[PTR_W-1:0]), .rd_data(rd_data)
    );

    spi_out_shift u_tx (
        .clk(clk), .rst(rst), .load(sel_start), .load_val(resp_q),
        .shift(bit_shift), .sdo(sdo)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            drv_q  <= 1'b0;
            cfg_q  <= 1'b0;
            oe_q   <= 1'b0;
            own_q  <= '0;
            ptr_q  <= '0;
            resp_q <= '0;
        end else if (frame_ok) begin
            if (frm.ca == CA_BCAST)       oe_q <= 1'b0;
            else if (frm.ca == own_q)     oe_q <= 1'b1;
            else if (frm.ca != CA_SHARED) oe_q <= 1'b0;
            if (hit) begin
                resp_q <= (cmd == CMD_RD) ? rd_data : '0;
                case (cmd)
                    CMD_DRV_ON: begin
                        drv_q <= 1'b1;
                        cfg_q <= 1'b0;
                    end
                    CMD_DRV_OFF: drv_q <= 1'b0;
                    CMD_CFG:     cfg_q <= 1'b1;
                    CMD_PTR:     ptr_q <= frm.body[PTR_W-1:0];
                    CMD_SET_CA:  own_q <= frm.body[CA_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    assign sdo_oe   = oe_q;
    assign drv_en   = drv_q;
    assign cfg_mode = cfg_q;

    AST_DRV_HOLD: assert property (@(posedge clk) disable iff (rst) !frame_ok |=> $stable(drv_en)); // R4
    AST_OE_HOLD: assert property (@(posedge clk) disable iff (rst) !frame_ok |=> $stable(sdo_oe)); // R3
    AST_CA_HOLD: assert property (@(posedge clk) disable iff (rst) !frame_ok |=> $stable(own_q)); // R9
    AST_CFG_EXIT: assert property (@(posedge clk) disable iff (rst) (hit && cmd == CMD_DRV_ON) |=> (drv_en && !cfg_mode)); // R5
    AST_BCAST_RELEASE: assert property (@(posedge clk) disable iff (rst) (frame_ok && frm.ca == CA_BCAST) |=> !sdo_oe); // R3
endmodule

// File: tb/test_spi_addr_cmd_decoder.sv
module test_spi_addr_cmd_decoder;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic sdi = 1'b0;
    logic sdo, sdo_oe, drv_en, cfg_mode;

    int n_chk = 0;
    int n_fail = 0;
    bit hold = 1'b1;
    bit done = 1'b0;

    logic       m_drv, m_cfg, m_oe;
    logic [3:0] m_own;
    logic [4:0] m_ptr;
    logic [15:0] m_resp;
    logic [15:0] m_regs [8];

    always #5 clk = ~clk;

    spi_addr_cmd_decoder i_spi_addr_cmd_decoder (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe), .drv_en(drv_en), .cfg_mode(cfg_mode)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_drv = 0; m_cfg = 0; m_oe = 0; m_own = 0; m_ptr = 0; m_resp = 0;
        for (int i = 0; i < 8; i++) m_regs[i] = 16'hA500 + 16'(i);
    endtask

    task automatic model_apply(input logic [15:0] f);
        logic [3:0]  ca;
        logic [11:0] b;
        bit          acc;
        ca = f[15:12];
        b  = f[11:0];
        acc = (ca == m_own) || (ca == 4'h0) || (ca == 4'hF);
        if (ca == 4'hF) m_oe = 0;
        else if (ca == m_own) m_oe = 1;
        else if (ca != 4'h0) m_oe = 0;
        if (acc) begin
            m_resp = 16'h0000;
            if (f[15:4] == 12'hFDA) m_own = f[3:0];
            else if (b == 12'h009) begin m_drv = 1; m_cfg = 0; end
            else if (b == 12'h00A) m_drv = 0;
            else if (b == 12'h222) m_cfg = 1;
            else if (b == 12'h542) begin end
            else if (b == 12'h708) begin
                for (int i = 0; i < 8; i++) m_regs[i] = 16'hA500 + 16'(i);
            end
            else if (b[11:5] == 7'b0001000) m_resp = (b[4:0] < 8) ? m_regs[b[2:0]] : 16'h0000;
            else if (b[11:5] == 7'b1100000) m_ptr = b[4:0];
            else if (b[11:8] == 4'hA) begin
                if (m_cfg && m_ptr < 8) m_regs[m_ptr[2:0]][15:8] = b[7:0];
            end
            else if (b[11:8] == 4'hB) begin
                if (m_cfg && m_ptr < 8) m_regs[m_ptr[2:0]][7:0] = b[7:0];
            end
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [15:0] f, input int nbits, output logic [15:0] got);
        got = '0;
        cs_n = 1'b0;
        wait_clk(6);
        for (int i = 0; i < nbits; i++) begin
            sdi = (i < 16) ? f[15-i] : 1'b0;
            wait_clk(6);
            got = {got[14:0], sdo};
            sclk = 1'b1;
            wait_clk(6);
            sclk = 1'b0;
        end
        wait_clk(6);
        hold = 1'b1;
        cs_n = 1'b1;
        wait_clk(10);
        if (nbits == 16) model_apply(f);
        hold = 1'b0;
        wait_clk(4);
    endtask

    task automatic frame(input logic [15:0] f, input string tag);
        logic [15:0] exp;
        logic [15:0] got;
        exp = m_resp;
        send(f, 16, got);
        check({tag, " sdo word R7"}, 32'(got), 32'(exp));
    endtask

    always @(negedge clk) begin
        if (!hold && !done) begin
            check("R4 drv_en", 32'(drv_en), 32'(m_drv));
            check("R5 cfg_mode", 32'(cfg_mode), 32'(m_cfg));
            check("R3 sdo_oe", 32'(sdo_oe), 32'(m_oe));
        end
    end

    initial begin
        logic [15:0] junk;
        model_reset();
        wait_clk(5);
        rst = 1'b0;
        wait_clk(2);
        hold = 1'b0;
        check("R11 drv_en after reset", 32'(drv_en), 0);
        check("R11 cfg_mode after reset", 32'(cfg_mode), 0);
        check("R11 sdo_oe after reset", 32'(sdo_oe), 0);
        wait_clk(3);
        frame(16'h0103, "R11 read default reg3");
        frame(16'h0542, "R11 default reg3 out");
        frame(16'h0009, "R4 enable");
        frame(16'h000A, "R4 disable");
        send(16'h0009, 15, junk);
        check("R1 15-clock frame drv_en", 32'(drv_en), 0);
        send(16'h0009, 17, junk);
        check("R1 17-clock frame drv_en", 32'(drv_en), 0);
        frame(16'hFDA5, "R9 set chip address");
        check("R3 broadcast releases sdo", 32'(sdo_oe), 0);
        frame(16'h3009, "R2 foreign enable");
        check("R2 foreign frame ignored", 32'(drv_en), 0);
        frame(16'h5222, "R5 enter cfg");
        check("R3 own address drives sdo", 32'(sdo_oe), 1);
        frame(16'h0C02, "R6 pointer via shared address");
        check("R3 shared address keeps sdo", 32'(sdo_oe), 1);
        frame(16'h5A12, "R6 write high");
        frame(16'h5B34, "R6 write low");
        frame(16'h5102, "R6 read reg2");
        frame(16'h5542, "R6 reg2 out");
        frame(16'h5542, "R7 nop stages zero");
        frame(16'h5009, "R5 enable leaves cfg");
        frame(16'h5AFF, "R6 write outside cfg");
        frame(16'h5102, "R6 read after blocked write");
        frame(16'h5542, "R6 reg2 unchanged");
        frame(16'h5123, "R10 unknown code");
        frame(16'h5542, "R10 nop");
        frame(16'hF542, "R3 broadcast");
        frame(16'h7542, "R3 foreign stays released");
        frame(16'h5542, "R3 own again");
        frame(16'h9542, "R3 foreign releases");
        frame(16'h5708, "R8 soft reset");
        frame(16'h5102, "R8 read reg2");
        frame(16'h5114, "R8 reg2 default out");
        frame(16'h5542, "R7 out of range reads zero");
        frame(16'hEDA7, "R9 pattern at foreign address");
        frame(16'h5222, "R9 chip address kept");
        frame(16'h0C09, "R6 pointer past bank");
        frame(16'h5A77, "R6 write past bank");
        frame(16'h5107, "R6 read reg7");
        frame(16'h5542, "R6 reg7 untouched");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired R1 actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule